// File: doc/BRIEF.md
# Strobe-Driven Auto-Incrementing Address Pointer

This block keeps an 8-bit address pointer for a simple multiplexed external bus. The host places an address on the shared data lines and raises the address latch strobe, and the pointer takes that value. Each later pulse on the read strobe moves the pointer forward by one. In this way the host can walk through consecutive locations after sending only one address.

All logic runs on the system clock. The two strobes come from outside the clock domain, so each one passes through a synchronizer. Its edges are then found by comparing the current synchronized level with a registered earlier copy. The bus is sampled on every clock and delayed so that it lines up with the synchronized latch edge.

No register is clocked by a strobe, and no register is loaded through an asynchronous path. The only asynchronous action is the reset, which clears registers to zero. This keeps the design free of combinational loops on fabrics that have no asynchronous load. A one-cycle pulse on a separate output marks each load, and another marks each increment.

Top module: `strobe_addr_ptr`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, addr_o is 0x00 and both load_o and inc_o are low.
- R2: A rising edge on ale_i loads addr_o with the value that bus_i held at the clock edge where ale_i was first sampled high. The bus must be held stable for at least one cycle before that edge and three cycles after it. load_o is high for the one cycle in which the new address first appears.
- R3: A falling edge on rd_i, with no load seen in the same cycle, raises addr_o by exactly one. inc_o is high for the one cycle in which the new address first appears.
- R4: An increment from 0xFF gives 0x00. The pointer wraps and does not saturate.
- R5: When the latch rising edge and the read falling edge are detected in the same cycle, only the load takes place: addr_o takes the bus value, load_o pulses and inc_o stays low. load_o and inc_o are never high together.
- R6: Each strobe pulse causes exactly one load or one increment, however many clock cycles it lasts. addr_o does not change in any cycle that has no load or increment.
- R7: After an input change is driven between clock edges, addr_o keeps its old value through the next two rising clock edges and shows the new value after the third.
- R8: A falling edge on ale_i, a rising edge on rd_i, and bus_i changes while no latch edge is present all leave addr_o unchanged and cause no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset; clears all registers |
| bus_i | input | 8 | Shared data bus carrying the address to load |
| ale_i | input | 1 | Address latch strobe, asynchronous; loads on its rising edge |
| rd_i | input | 1 | Read strobe, asynchronous; increments on its falling edge |
| addr_o | output | 8 | Current address pointer |
| load_o | output | 1 | One-cycle pulse marking a load |
| inc_o | output | 1 | One-cycle pulse marking an increment |

## Verification
The checker takes for granted that each strobe level lasts at least one system clock cycle, so that the synchronizer sees every pulse. It also takes for granted that the bus is steady across the sampling window of each latch edge, so the aligned bus value is the intended address. The stimulus changes inputs only on falling clock edges and holds every strobe level for several cycles. It keeps the bus fixed from one cycle before each latch rise until well after the strobe has fallen again. The only bus changes come while the latch strobe is idle, and these are there to show that they are ignored.

// File: rtl/strobe_addr_pkg.sv
package strobe_addr_pkg;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_LOAD = 2'd1,
    EV_INC  = 2'd2
  } ptr_ev_e;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int unsigned STAGES = 2,
  parameter bit          RISE   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic edge_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;
  logic            level;
  logic            prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_i};
  end

  assign level = sh_q[STAGES-1];
  assign prev  = sh_q[STAGES];

  generate
    if (RISE) begin : g_rise
      assign edge_o = level & ~prev;
    end else begin : g_fall
      assign edge_o = ~level & prev;
    end
  endgenerate
endmodule

// File: rtl/bus_align.sv
module bus_align #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] bus_o
);
  logic [W-1:0] pipe_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[0] <= '0;
          else         pipe_q[0] <= bus_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[i] <= '0;
          else         pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  assign bus_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/addr_counter.sv
module addr_counter
  import strobe_addr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ev_i,
  input  logic         inc_ev_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] addr_o,
  output logic         load_o,
  output logic         inc_o
);
  ptr_ev_e      ev;
  logic [W-1:0] addr_q;
  logic [W-1:0] addr_d;

  // load wins over increment
  always_comb begin
    if (load_ev_i)     ev = EV_LOAD;
    else if (inc_ev_i) ev = EV_INC;
    else               ev = EV_NONE;
  end

  always_comb begin
    unique case (ev)
      EV_LOAD: addr_d = load_data_i;
      EV_INC:  addr_d = addr_q + W'(1);
      default: addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      load_o <= 1'b0;
      inc_o  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      load_o <= (ev == EV_LOAD);
      inc_o  <= (ev == EV_INC);
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/strobe_addr_ptr.sv
module strobe_addr_ptr
  import strobe_addr_pkg::*;
#(
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_i,
  input  logic              ale_i,
  input  logic              rd_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              load_o,
  output logic              inc_o
);
  logic              ale_rise;
  logic              rd_fall;
  logic [ADDR_W-1:0] load_data;

  strobe_edge #(.STAGES(SYNC_STAGES), .RISE(1'b1)) u_ale_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(ale_i),
    .edge_o  (ale_rise)
  );

  strobe_edge #(.STAGES(SYNC_STAGES), .RISE(1'b0)) u_rd_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(rd_i),
    .edge_o  (rd_fall)
  );

  // depth matches synchronizer so the load value is the bus at first strobe sample
  bus_align #(.W(ADDR_W), .DEPTH(SYNC_STAGES)) u_bus_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bus_i (bus_i),
    .bus_o (load_data)
  );

  addr_counter #(.W(ADDR_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_ev_i  (ale_rise),
    .inc_ev_i   (rd_fall),
    .load_data_i(load_data),
    .addr_o     (addr_o),
    .load_o     (load_o),
    .inc_o      (inc_o)
  );
endmodule

// File: rtl/strobe_addr_ptr_chk.sv
module strobe_addr_ptr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] addr_o,
  input logic         load_o,
  input logic         inc_o,
  input logic         ale_rise,
  input logic         rd_fall,
  input logic [W-1:0] load_data
);
  p_load_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> addr_o == $past(load_data));

  p_inc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |-> addr_o == W'($past(addr_o) + W'(1)));

  p_load_priority_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_rise && rd_fall) |=> (load_o && !inc_o));

  p_pulse_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_o && inc_o));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_o && !inc_o) |-> addr_o == $past(addr_o));

  p_single_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  p_single_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |=> !inc_o);
endmodule

bind strobe_addr_ptr strobe_addr_ptr_chk #(.W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_o   (addr_o),
  .load_o   (load_o),
  .inc_o    (inc_o),
  .ale_rise (ale_rise),
  .rd_fall  (rd_fall),
  .load_data(load_data)
);

// File: tb/strobe_addr_ptr_tb_top.sv
`timescale 1ns/1ps
module strobe_addr_ptr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus = 8'h00;
  logic       ale = 1'b0;
  logic       rd = 1'b1;
  logic [7:0] addr;
  logic       load_p;
  logic       inc_p;

  int checks = 0;
  int failures = 0;
  int n_load = 0;
  int n_inc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  strobe_addr_ptr dut_i (
    .clk_i (clk),
    .rst_ni(rst_n),
    .bus_i (bus),
    .ale_i (ale),
    .rd_i  (rd),
    .addr_o(addr),
    .load_o(load_p),
    .inc_o (inc_p)
  );

  always @(negedge clk) begin
    if (rst_n && load_p) n_load++;
    if (rst_n && inc_p)  n_inc++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] v);
    bus = v; tick(1);
    ale = 1'b1; tick(4);
    ale = 1'b0; tick(4);
  endtask

  task automatic do_read(input int len);
    rd = 1'b0; tick(len);
    rd = 1'b1; tick(4);
  endtask

  task automatic t_reset;
    chk("R1 addr in reset", addr, 0);
    chk("R1 load_o in reset", load_p, 0);
    chk("R1 inc_o in reset", inc_p, 0);
    rst_n = 1'b1; tick(1);
    chk("R1 addr after release", addr, 0);
    chk("R1 pulses after release", {load_p, inc_p}, 0);
    tick(4);
  endtask

  task automatic t_load;
    int l0 = n_load;
    do_load(8'h5A);
    chk("R2 loaded value", addr, 8'h5A);
    chk("R2 one load pulse", n_load - l0, 1);
    do_load(8'hC3);
    chk("R2 second load", addr, 8'hC3);
  endtask

  task automatic t_latency;
    bus = 8'h21; tick(1);
    ale = 1'b1; tick(2);
    chk("R7 unchanged after two edges", addr, 8'hC3);
    tick(1);
    chk("R7 new value after third edge", addr, 8'h21);
    tick(3); ale = 1'b0; tick(4);
  endtask

  task automatic t_inc;
    int i0;
    do_load(8'h10);
    i0 = n_inc;
    do_read(3);
    chk("R3 inc by one", addr, 8'h11);
    do_read(2);
    do_read(5);
    chk("R3 three reads", addr, 8'h13);
    chk("R3 inc pulses", n_inc - i0, 3);
  endtask

  task automatic t_wrap;
    do_load(8'hFE);
    do_read(3);
    chk("R4 to 0xFF", addr, 8'hFF);
    do_read(3);
    chk("R4 wrap to 0x00", addr, 8'h00);
  endtask

  task automatic t_long;
    int i0 = n_inc;
    int l0 = n_load;
    do_read(40);
    chk("R6 long read one inc", addr, 8'h01);
    chk("R6 long read pulse count", n_inc - i0, 1);
    bus = 8'h77; tick(1);
    ale = 1'b1; tick(30); ale = 1'b0; tick(4);
    chk("R6 long latch one load", n_load - l0, 1);
    chk("R6 long latch value", addr, 8'h77);
  endtask

  task automatic t_simul;
    int l0 = n_load;
    int i0 = n_inc;
    bus = 8'h40; tick(1);
    ale = 1'b1; rd = 1'b0; tick(5);
    chk("R5 load wins value", addr, 8'h40);
    chk("R5 load pulse", n_load - l0, 1);
    chk("R5 no inc pulse", n_inc - i0, 0);
    ale = 1'b0; rd = 1'b1; tick(5);
  endtask

  task automatic t_ignored;
    int l0 = n_load;
    int i0 = n_inc;
    bus = 8'h99; tick(6);
    bus = 8'h0F; tick(6);
    chk("R8 bus change ignored", addr, 8'h40);
    rd = 1'b0; tick(6);
    chk("R8 inc on rd fall only", addr, 8'h41);
    rd = 1'b1; tick(6);
    chk("R8 rd rise ignored", addr, 8'h41);
    ale = 1'b1; tick(6);
    chk("R8 load on rise", addr, 8'h0F);
    ale = 1'b0; bus = 8'hEE; tick(6);
    chk("R8 ale fall ignored", addr, 8'h0F);
    chk("R8 event counts", (n_load - l0) * 16 + (n_inc - i0), 16 + 1);
  endtask

  initial begin
    tick(3);
    t_reset;
    t_load;
    t_latency;
    t_inc;
    t_wrap;
    t_long;
    t_simul;
    t_ignored;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule